// File: doc/BRIEF.md
# Rectangular Frame-Buffer Transfer Address Generator

This block turns a rectangle header and a stream of 32-bit data words into pixel requests for a frame buffer of 1024 columns by 512 rows of 16-bit pixels. A command parser hands it the rectangle's corner and size fields and a read/write flag. After that, every accepted data word stands for two pixels. The block scans the rectangle left to right, then moves down one row. For each word it issues one request that carries two pixel addresses.

Progress within a row is kept between words, so a transfer may stall for any number of cycles between bursts and then resume at the right column. Read transfers hold an image-busy flag and, at start, issue a priming request for the first two pixels. Write transfers end with a one-cycle completion pulse that reports the original rectangle, so that cached copies of that region can be invalidated. An open-write indicator tells the command parser that incoming words belong to the transfer and must not be decoded as commands.

Top module: `vramXferGen`

## Requirements
- R1: The corner is taken from `hdrX` (column) and `hdrY` (row). A pixel's address is row*1024 + column, that is {row, column}.
- R2: A width field of 0 means 1024 columns, and a height field of 0 means 512 rows. Any other value is taken as it is.
- R3: Each accepted word yields two pixels. Bits [15:0] go to the lower-ordered pixel (`reqAddrA`/`reqDataA`) and bits [31:16] to the next pixel (`reqAddrB`/`reqDataB`). Pixels advance along a row first, and the column wraps modulo 1024.
- R4: When the rectangle runs past row 511, the row index wraps to 0.
- R5: The position is kept across idle gaps between words. A word while no transfer is open is ignored. A word in the same cycle as a start is ignored.
- R6: If only one pixel of the rectangle remains, the final word's second pixel is disabled (`reqEnB`=0).
- R7: Starting a read sets `imgBusy`. It also issues a read request for (x, y) and (x+1 mod 1024, y) without advancing the position. `imgBusy` clears together with the request that carries the last pixel.
- R8: The request carrying a write's last pixel comes with a one-cycle `doneValid`, and `doneX/Y/W/H` give the original rectangle, with the decoded size. Reads give no completion pulse.
- R9: A start while a transfer is open abandons the old one, which gives no completion pulse. It also sets `errFlag`, which stays set until reset.
- R10: `xferWriteOpen` is high exactly while a write transfer is open.
- R11: All outputs are registered. A request appears in the cycle after its word or start strobe and lasts one cycle. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Load a new rectangle header |
| startIsRead | input | 1 | 1 = read transfer, 0 = write |
| hdrX | input | 10 | Corner column |
| hdrY | input | 9 | Corner row |
| hdrW | input | 10 | Width field (0 = 1024) |
| hdrH | input | 9 | Height field (0 = 512) |
| wordValid | input | 1 | A data word is offered |
| dataWord | input | 32 | Two pixels, low half first |
| reqValid | output | 1 | Pixel request this cycle |
| reqWrite | output | 1 | 1 = write request, 0 = read |
| reqAddrA | output | 19 | Address of first pixel |
| reqAddrB | output | 19 | Address of second pixel |
| reqEnB | output | 1 | Second pixel is part of the request |
| reqDataA | output | 16 | Write data of first pixel |
| reqDataB | output | 16 | Write data of second pixel |
| imgBusy | output | 1 | Read transfer open |
| xferWriteOpen | output | 1 | Write transfer open; words bypass command decoding |
| doneValid | output | 1 | Write transfer finished |
| doneX | output | 10 | Finished rectangle column |
| doneY | output | 9 | Finished rectangle row |
| doneW | output | 11 | Finished rectangle width |
| doneH | output | 10 | Finished rectangle height |
| errFlag | output | 1 | Sticky: transfer restarted while open |

## Verification
A small aligned write sent back to back checks the basic address order and data-lane mapping. A 3x3 rectangle placed at column 1022 and row 510 is fed with idle gaps. This one case separates column wrap, row wrap and the odd final pixel, and also shows that progress survives the pauses. A read with gaps checks the priming request, the busy window and the absence of a completion pulse. Words sent after it finishes check that they are ignored. Zero-valued size fields are exercised as a full-width single row and as a single-column, 512-row strip that wraps. A mid-transfer restart, including a word in the same cycle as the start, separates abandonment and the sticky error from a normal completion.

// File: rtl/vxg_pkg.sv
package vxg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture header, reset position
    logic prime;  // issue read priming request (with load)
    logic step;   // consume one word, emit request, advance
    logic wr;     // current transfer is a write
  } vxgCtl_t;
endpackage

// File: rtl/vxg_datapath.sv
module vxg_datapath #(
  parameter int COL_BITS = 10,
  parameter int ROW_BITS = 9,
  parameter int PIX_BITS = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  vxg_pkg::vxgCtl_t          ctl,
  input  logic [COL_BITS-1:0]       hdrX,
  input  logic [ROW_BITS-1:0]       hdrY,
  input  logic [COL_BITS-1:0]       hdrW,
  input  logic [ROW_BITS-1:0]       hdrH,
  input  logic [2*PIX_BITS-1:0]     dataWord,
  output logic                      lastA,
  output logic                      lastB,
  output logic                      reqValid,
  output logic                      reqWrite,
  output logic [ROW_BITS+COL_BITS-1:0] reqAddrA,
  output logic [ROW_BITS+COL_BITS-1:0] reqAddrB,
  output logic                      reqEnB,
  output logic [PIX_BITS-1:0]       reqDataA,
  output logic [PIX_BITS-1:0]       reqDataB,
  output logic [COL_BITS-1:0]       rectX,
  output logic [ROW_BITS-1:0]       rectY,
  output logic [COL_BITS:0]         rectW,
  output logic [ROW_BITS:0]         rectH
);
  localparam int CW = COL_BITS + 1;
  localparam int RW = ROW_BITS + 1;
  localparam logic [CW-1:0] W_MAX = CW'(1) << COL_BITS;
  localparam logic [RW-1:0] H_MAX = RW'(1) << ROW_BITS;
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [RW-1:0] H_ONE = RW'(1);
  localparam logic [ROW_BITS-1:0] Y_ONE = ROW_BITS'(1);
  localparam logic [COL_BITS-1:0] X_ONE = COL_BITS'(1);

  logic [COL_BITS-1:0] baseX;
  logic [ROW_BITS-1:0] curY;
  logic [CW-1:0]       wLen, col;
  logic [RW-1:0]       hLeft;

  // zero field selects the maximum extent
  logic [CW-1:0] wDec;
  logic [RW-1:0] hDec;
  assign wDec = (hdrW == '0) ? W_MAX : {1'b0, hdrW};
  assign hDec = (hdrH == '0) ? H_MAX : {1'b0, hdrH};

  // pixel A at current position, pixel B one step further
  logic [CW-1:0]       colInc, colB, colBInc, colN;
  logic [ROW_BITS-1:0] yB, yN;
  logic [RW-1:0]       hB, hN;
  logic                endA, endB;
  logic [COL_BITS-1:0] xA, xB;

  always_comb begin
    colInc  = col + C_ONE;
    endA    = (colInc == wLen);
    lastA   = endA && (hLeft == H_ONE);
    colB    = endA ? '0 : colInc;
    yB      = endA ? curY + Y_ONE : curY;
    hB      = endA ? hLeft - H_ONE : hLeft;
    colBInc = colB + C_ONE;
    endB    = (colBInc == wLen);
    lastB   = endB && (hB == H_ONE);
    colN    = endB ? '0 : colBInc;
    yN      = endB ? yB + Y_ONE : yB;
    hN      = endB ? hB - H_ONE : hB;
    xA      = baseX + col[COL_BITS-1:0];
    xB      = baseX + colB[COL_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseX <= '0; curY <= '0; wLen <= '0; col <= '0; hLeft <= '0;
      reqValid <= 1'b0; reqWrite <= 1'b0; reqEnB <= 1'b0;
      reqAddrA <= '0; reqAddrB <= '0; reqDataA <= '0; reqDataB <= '0;
      rectX <= '0; rectY <= '0; rectW <= '0; rectH <= '0;
    end else begin
      reqValid <= 1'b0;
      reqEnB   <= 1'b0;
      if (ctl.load) begin
        baseX <= hdrX;  curY  <= hdrY;
        wLen  <= wDec;  hLeft <= hDec;  col <= '0;
        rectX <= hdrX;  rectY <= hdrY;
        rectW <= wDec;  rectH <= hDec;
        if (ctl.prime) begin
          reqValid <= 1'b1;
          reqWrite <= 1'b0;
          reqEnB   <= 1'b1;
          reqAddrA <= {hdrY, hdrX};
          reqAddrB <= {hdrY, hdrX + X_ONE};
        end
      end else if (ctl.step) begin
        reqValid <= 1'b1;
        reqWrite <= ctl.wr;
        reqEnB   <= !lastA;
        reqAddrA <= {curY, xA};
        reqAddrB <= {yB, xB};
        reqDataA <= dataWord[PIX_BITS-1:0];
        reqDataB <= dataWord[2*PIX_BITS-1:PIX_BITS];
        col      <= colN;
        curY     <= yN;
        hLeft    <= hN;
      end
    end
  end
endmodule

// File: rtl/vxg_ctrl.sv
module vxg_ctrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             startIsRead,
  input  logic             wordValid,
  input  logic             lastA,
  input  logic             lastB,
  output vxg_pkg::vxgCtl_t ctl,
  output logic             imgBusy,
  output logic             xferWriteOpen,
  output logic             doneValid,
  output logic             errFlag
);
  logic active, isRead;
  logic finishing;

  always_comb begin
    ctl.load  = startValid;
    ctl.prime = startValid && startIsRead;
    ctl.step  = !startValid && wordValid && active;
    ctl.wr    = !isRead;
    finishing = lastA || lastB;
  end

  assign xferWriteOpen = active && !isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0; isRead <= 1'b0; imgBusy <= 1'b0;
      doneValid <= 1'b0; errFlag <= 1'b0;
    end else begin
      doneValid <= 1'b0;
      if (ctl.load) begin
        errFlag <= errFlag || active;
        active  <= 1'b1;
        isRead  <= startIsRead;
        imgBusy <= startIsRead;
      end else if (ctl.step && finishing) begin
        active    <= 1'b0;
        imgBusy   <= 1'b0;
        doneValid <= !isRead;
      end
    end
  end
endmodule

// File: rtl/vramXferGen.sv
module vramXferGen #(
  parameter int COL_BITS = 10,
  parameter int ROW_BITS = 9,
  parameter int PIX_BITS = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startValid,
  input  logic                         startIsRead,
  input  logic [COL_BITS-1:0]          hdrX,
  input  logic [ROW_BITS-1:0]          hdrY,
  input  logic [COL_BITS-1:0]          hdrW,
  input  logic [ROW_BITS-1:0]          hdrH,
  input  logic                         wordValid,
  input  logic [2*PIX_BITS-1:0]        dataWord,
  output logic                         reqValid,
  output logic                         reqWrite,
  output logic [ROW_BITS+COL_BITS-1:0] reqAddrA,
  output logic [ROW_BITS+COL_BITS-1:0] reqAddrB,
  output logic                         reqEnB,
  output logic [PIX_BITS-1:0]          reqDataA,
  output logic [PIX_BITS-1:0]          reqDataB,
  output logic                         imgBusy,
  output logic                         xferWriteOpen,
  output logic                         doneValid,
  output logic [COL_BITS-1:0]          doneX,
  output logic [ROW_BITS-1:0]          doneY,
  output logic [COL_BITS:0]            doneW,
  output logic [ROW_BITS:0]            doneH,
  output logic                         errFlag
);
  vxg_pkg::vxgCtl_t ctl;
  logic lastA, lastB;

  vxg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startIsRead(startIsRead),
    .wordValid(wordValid), .lastA(lastA), .lastB(lastB), .ctl(ctl),
    .imgBusy(imgBusy), .xferWriteOpen(xferWriteOpen),
    .doneValid(doneValid), .errFlag(errFlag)
  );

  vxg_datapath #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS), .PIX_BITS(PIX_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hdrX(hdrX), .hdrY(hdrY), .hdrW(hdrW), .hdrH(hdrH), .dataWord(dataWord),
    .lastA(lastA), .lastB(lastB),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddrA(reqAddrA), .reqAddrB(reqAddrB),
    .reqEnB(reqEnB), .reqDataA(reqDataA), .reqDataB(reqDataB),
    .rectX(doneX), .rectY(doneY), .rectW(doneW), .rectH(doneH)
  );
endmodule

// File: rtl/vxg_checker.sv
module vxg_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic reqEnB,
  input logic imgBusy,
  input logic xferWriteOpen,
  input logic doneValid,
  input logic errFlag
);
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R8
  AST_DONE_WITH_WRITE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (reqValid && reqWrite && !imgBusy)); // R8
  AST_ENB_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqEnB |-> reqValid); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9
  AST_BUSY_NO_WRITE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (imgBusy && reqValid) |-> !reqWrite); // R7
  AST_OPEN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    xferWriteOpen |-> !imgBusy); // R10
endmodule

bind vramXferGen vxg_checker u_vxgChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqEnB(reqEnB), .imgBusy(imgBusy), .xferWriteOpen(xferWriteOpen),
  .doneValid(doneValid), .errFlag(errFlag)
);

// File: tb/test_vramXferGen.sv
module test_vramXferGen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0, startIsRead = 1'b0, wordValid = 1'b0;
  logic [9:0] hdrX = '0, hdrW = '0;
  logic [8:0] hdrY = '0, hdrH = '0;
  logic [31:0] dataWord = '0;
  logic reqValid, reqWrite, reqEnB, imgBusy, xferWriteOpen, doneValid, errFlag;
  logic [18:0] reqAddrA, reqAddrB;
  logic [15:0] reqDataA, reqDataB;
  logic [9:0] doneX;
  logic [8:0] doneY;
  logic [10:0] doneW;
  logic [9:0] doneH;

  always #5 clk = ~clk;

  vramXferGen i_vramXferGen (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startIsRead(startIsRead),
    .hdrX(hdrX), .hdrY(hdrY), .hdrW(hdrW), .hdrH(hdrH),
    .wordValid(wordValid), .dataWord(dataWord),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddrA(reqAddrA), .reqAddrB(reqAddrB),
    .reqEnB(reqEnB), .reqDataA(reqDataA), .reqDataB(reqDataB),
    .imgBusy(imgBusy), .xferWriteOpen(xferWriteOpen), .doneValid(doneValid),
    .doneX(doneX), .doneY(doneY), .doneW(doneW), .doneH(doneH), .errFlag(errFlag)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  string phaseTag = "R1";

  // behavioural reference
  int mActive, mRead, mX, mY, mW, mH, mCol, mRow;
  int eValid, eWrite, eEnB, eDone, eBusy, eErr;
  int eAddrA, eAddrB, eDataA, eDataB, eRX, eRY, eRW, eRH;

  function automatic int curAddr();
    return ((mY + mRow) % 512) * 1024 + ((mX + mCol) % 1024);
  endfunction

  function automatic void advance();
    mCol++;
    if (mCol == mW) begin mCol = 0; mRow++; end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mRead = 0; eValid = 0; eWrite = 0; eEnB = 0; eDone = 0;
      eBusy = 0; eErr = 0; eAddrA = 0; eAddrB = 0; eDataA = 0; eDataB = 0;
      eRX = 0; eRY = 0; eRW = 0; eRH = 0; mCol = 0; mRow = 0;
    end else begin
      eValid = 0; eEnB = 0; eDone = 0;
      if (startValid) begin
        if (mActive != 0) eErr = 1;
        mActive = 1; mRead = startIsRead;
        mX = hdrX; mY = hdrY;
        mW = ((int'(hdrW) - 1) & 1023) + 1;
        mH = ((int'(hdrH) - 1) & 511) + 1;
        mCol = 0; mRow = 0;
        eRX = mX; eRY = mY; eRW = mW; eRH = mH;
        eBusy = mRead;
        if (mRead != 0) begin
          eValid = 1; eWrite = 0; eEnB = 1;
          eAddrA = mY * 1024 + mX;
          eAddrB = mY * 1024 + ((mX + 1) % 1024);
        end
      end else if (wordValid && mActive != 0) begin
        eValid = 1; eWrite = (mRead == 0);
        eAddrA = curAddr(); eDataA = dataWord[15:0];
        advance();
        if (mRow < mH) begin
          eEnB = 1; eAddrB = curAddr(); eDataB = dataWord[31:16];
          advance();
        end
        if (mRow >= mH) begin
          mActive = 0; eBusy = 0; eDone = (mRead == 0);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(int'(reqValid) == eValid, "R11 reqValid", reqValid, eValid);
      check(int'(imgBusy) == eBusy, "R7 imgBusy", imgBusy, eBusy);
      check(int'(errFlag) == eErr, "R9 errFlag", errFlag, eErr);
      check(int'(doneValid) == eDone, "R8 doneValid", doneValid, eDone);
      check(int'(xferWriteOpen) == ((mActive != 0 && mRead == 0) ? 1 : 0),
            "R10 xferWriteOpen", xferWriteOpen, (mActive != 0 && mRead == 0));
      if (eValid != 0) begin
        check(int'(reqWrite) == eWrite, "R3 reqWrite", reqWrite, eWrite);
        check(int'(reqAddrA) == eAddrA, {phaseTag, " reqAddrA"}, reqAddrA, eAddrA);
        check(int'(reqEnB) == eEnB, "R6 reqEnB", reqEnB, eEnB);
        if (eEnB != 0)
          check(int'(reqAddrB) == eAddrB, {phaseTag, " reqAddrB"}, reqAddrB, eAddrB);
        if (eWrite != 0) begin
          check(int'(reqDataA) == eDataA, "R3 reqDataA", reqDataA, eDataA);
          if (eEnB != 0)
            check(int'(reqDataB) == eDataB, "R3 reqDataB", reqDataB, eDataB);
        end
      end
      if (eDone != 0) begin
        check(int'(doneX) == eRX, "R8 doneX", doneX, eRX);
        check(int'(doneY) == eRY, "R8 doneY", doneY, eRY);
        check(int'(doneW) == eRW, "R8 doneW", doneW, eRW);
        check(int'(doneH) == eRH, "R8 doneH", doneH, eRH);
      end
    end
  end

  task automatic startXfer(input bit rd, input int x, input int y, input int w, input int h);
    @(negedge clk);
    startValid = 1'b1; startIsRead = rd;
    hdrX = 10'(x); hdrY = 9'(y); hdrW = 10'(w); hdrH = 9'(h);
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic sendWords(input int n, input int gap, input int seed);
    for (int i = 0; i < n; i++) begin
      dataWord = 32'hC0DE_0000 ^ 32'((seed + i) * 32'h0001_0003);
      wordValid = 1'b1;
      @(negedge clk);
      wordValid = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R11 watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state (R11)
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: small aligned write, back to back
    phaseTag = "R1";
    startXfer(0, 10, 5, 4, 2);
    sendWords(4, 0, 1);
    repeat (2) @(negedge clk);
    // R4: column and row wrap, odd pixel count, gaps (R5, R6)
    phaseTag = "R4";
    startXfer(0, 1022, 510, 3, 3);
    sendWords(5, 2, 20);
    repeat (2) @(negedge clk);
    // R5: read with gaps, then words while idle are ignored (R7)
    phaseTag = "R5";
    startXfer(1, 200, 100, 5, 2);
    sendWords(5, 3, 40);
    sendWords(3, 1, 50);
    // R2: zero width field -> 1024 columns, one row
    phaseTag = "R2";
    startXfer(0, 0, 77, 0, 1);
    sendWords(512, 0, 60);
    // R2 with R4: one column, zero height field -> 512 rows, wraps
    startXfer(1, 7, 3, 1, 0);
    sendWords(256, 0, 90);
    repeat (2) @(negedge clk);
    // R9: restart while open, word coincident with start ignored
    phaseTag = "R9";
    startXfer(0, 30, 40, 6, 2);
    sendWords(2, 0, 100);
    @(negedge clk);
    startValid = 1'b1; startIsRead = 1'b0; wordValid = 1'b1;
    hdrX = 10'd64; hdrY = 9'd8; hdrW = 10'd2; hdrH = 9'd1;
    dataWord = 32'h1234_5678;
    @(negedge clk);
    startValid = 1'b0; wordValid = 1'b0;
    sendWords(1, 1, 110);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule